// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is a memory-mapped controller for a bank of general-purpose pins (32 by default). Software reaches it over a plain word-addressed register bus. The bus has an address, a write strobe, write data and combinational read data. Each pin has one bit in each of four read/write registers:

- **Direction:** 1 makes the pin an input, 0 makes it an output.
- **Output level:** the value driven on an output pin.
- **Blink enable:** hands the pin's driven value to a shared blink clock.
- **Input polarity:** inverts the value read back from the pin.

A fifth, read-only location returns the synchronized pin levels after the polarity inversion.

The pad side gives a per-pin output enable and driven value. Every pin that blinks toggles in lockstep from one free-running divider. The polarity-adjusted input is also exported as a port, so that a separate interrupt block can sample it. After reset every pin is an output that drives low. Because all registers can be read back, software can change one pin by read-modify-write without disturbing the other pins.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset, the four read/write registers read as zero. Every pin_oe bit is 1 and every pin_out bit is 0.
- R2: The registers sit at these word addresses: direction at 0x0, output level at 0x1, blink enable at 0x2, input polarity at 0x3. A write takes effect at the clock edge that samples it, and reading the address then returns the written word.
- R3: A write to one register leaves the other registers unchanged. A read-modify-write that changes one bit leaves the other bits of that register as they were.
- R4: pin_oe[i] is 1 exactly when direction bit i is 0.
- R5: When blink bit i is 0, pin_out[i] equals output-level bit i.
- R6: When blink bit i is 1, pin_out[i] follows a shared blink phase and ignores output-level bit i. All blinking pins carry the same value. The phase inverts once every BLINK_HALF clock cycles.
- R7: Reading word address 0x4 returns the pin inputs, delayed by a two-flop synchronizer, XOR the input-polarity register. pin_level_adj carries the same value. A change on pin_in appears after the second rising edge and not after the first.
- R8: Writes to 0x4 and to any address above 0x4 change no register. Reading an address above 0x4 returns zero.
- R9: An input pin (direction bit 1) has pin_oe low even when its blink bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for bus_addr (combinational) |
| pin_in | input | NPINS | Asynchronous pin levels from the pads |
| pin_oe | output | NPINS | Per-pin output enable |
| pin_out | output | NPINS | Per-pin driven value |
| pin_level_adj | output | NPINS | Synchronized input XOR polarity, for an interrupt block |

## Verification
The bench measures the synchronizer latency by reading the data-in word one edge and two edges after a pin change. A design with one stage too few or too many shows the new level at the wrong edge. It times the intervals between blink toggles and compares every blinking pin with the others. A wrong divider limit gives the wrong interval, and a per-pin or output-register-driven blink shows up as a mismatch between pins. It writes to the data-in address and to unmapped addresses, then reads every register back. A loose decoder therefore shows up as a corrupted register or as a nonzero read. A read-modify-write of one bit catches a register write that clobbers its neighbours.

// File: rtl/gpio_bank_pkg.sv
// Shared constants and address decode for the GPIO register bank.
// Assumes word addressing: each address selects one NPINS-wide register.
package gpio_bank_pkg;

    localparam int OFS_DIR   = 0;
    localparam int OFS_OUT   = 1;
    localparam int OFS_BLINK = 2;
    localparam int OFS_POL   = 3;
    localparam int OFS_DIN   = 4;

    localparam int NUM_RW_REGS = 4;

    typedef enum logic [2:0] {
        SEL_DIR   = 3'd0,
        SEL_OUT   = 3'd1,
        SEL_BLINK = 3'd2,
        SEL_POL   = 3'd3,
        SEL_DIN   = 3'd4,
        SEL_NONE  = 3'd7
    } gpio_sel_e;

    // Map a word address onto a register selector; anything else is unmapped.
    function automatic gpio_sel_e decode_addr(input int unsigned addr);
        case (addr)
            OFS_DIR:   return SEL_DIR;
            OFS_OUT:   return SEL_OUT;
            OFS_BLINK: return SEL_BLINK;
            OFS_POL:   return SEL_POL;
            OFS_DIN:   return SEL_DIN;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_blink_timer.sv
// Free-running divider that produces the shared blink phase.
// The phase inverts every HALF_PERIOD cycles. Assumes HALF_PERIOD >= 1.
module gpio_blink_timer #(
    parameter int HALF_PERIOD = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);

    localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    // Terminal count of the divider.
    always_comb begin
        wrap = (cnt_q == CNT_LAST);
    end

    // Advance the divider and invert the phase at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/gpio_input_path.sv
// Brings asynchronous pin levels into the clock domain through a
// SYNC_STAGES-deep flop chain and applies the per-pin polarity inversion.
// Assumes the pins are independent; no multi-bit coherence is given.
module gpio_input_path #(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pol,
    output logic [NPINS-1:0] level_adj
);

    logic [NPINS-1:0] stage_q [SYNC_STAGES];

    genvar s;
    generate
        for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= pin_in;
                end
            end else begin : g_next
                // Later stages retime the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    // Apply the programmable inversion to the synchronized level.
    always_comb begin
        level_adj = stage_q[SYNC_STAGES-1] ^ pol;
    end

endmodule

// File: rtl/gpio_regfile.sv
// Holds the direction, output-level, blink-enable and polarity registers.
// Decodes bus writes and multiplexes read data. Writes to the data-in and
// unmapped addresses are dropped; unmapped reads return zero.
module gpio_regfile #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic [NPINS-1:0]  din_adj,
    output logic [NPINS-1:0]  bus_rdata,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  blink_q,
    output logic [NPINS-1:0]  pol_q
);
    import gpio_bank_pkg::*;

    gpio_sel_e        sel;
    logic [NPINS-1:0] reg_q  [NUM_RW_REGS];
    logic             wr_hit [NUM_RW_REGS];

    // Decode the current bus address once for read and write.
    always_comb begin
        sel = decode_addr(32'(bus_addr));
    end

    genvar r;
    generate
        for (r = 0; r < NUM_RW_REGS; r++) begin : g_reg
            // Write strobe for this register.
            always_comb begin
                wr_hit[r] = bus_we && (sel == gpio_sel_e'(r));
            end

            // Storage: reset to zero (output, low, no blink, no inversion).
            always_ff @(posedge clk) begin
                if (!rst_n)         reg_q[r] <= '0;
                else if (wr_hit[r]) reg_q[r] <= bus_wdata;
            end
        end
    endgenerate

    // Name the register outputs.
    always_comb begin
        dir_q   = reg_q[OFS_DIR];
        out_q   = reg_q[OFS_OUT];
        blink_q = reg_q[OFS_BLINK];
        pol_q   = reg_q[OFS_POL];
    end

    // Read multiplexer.
    always_comb begin
        case (sel)
            SEL_DIR:   bus_rdata = reg_q[OFS_DIR];
            SEL_OUT:   bus_rdata = reg_q[OFS_OUT];
            SEL_BLINK: bus_rdata = reg_q[OFS_BLINK];
            SEL_POL:   bus_rdata = reg_q[OFS_POL];
            SEL_DIN:   bus_rdata = din_adj;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pad_ctrl.sv
// Per-pin pad driver selection: the output enable is the inverse of the
// direction bit, and the value is the blink phase or the output bit.
module gpio_pad_ctrl #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] out,
    input  logic [NPINS-1:0] blink,
    input  logic             phase,
    output logic [NPINS-1:0] oe,
    output logic [NPINS-1:0] drv
);

    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_pin
            // Drive enable and value for one pin.
            always_comb begin
                oe[i]  = ~dir[i];
                drv[i] = blink[i] ? phase : out[i];
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_bank.sv
// Top of the GPIO register bank: the register file, input synchronizer
// with polarity, shared blink divider and pad driver selection.
// Assumes a single clock domain for the bus; the pins are asynchronous.
module gpio_bank #(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int BLINK_HALF  = 25_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_level_adj
);

    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] blink_q;
    logic [NPINS-1:0] pol_q;
    logic [NPINS-1:0] din_adj;
    logic             blink_phase;

    gpio_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .din_adj   (din_adj),
        .bus_rdata (bus_rdata),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .blink_q   (blink_q),
        .pol_q     (pol_q)
    );

    gpio_input_path #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_inp (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .pol       (pol_q),
        .level_adj (din_adj)
    );

    gpio_blink_timer #(.HALF_PERIOD(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (blink_phase)
    );

    gpio_pad_ctrl #(.NPINS(NPINS)) u_pad (
        .dir   (dir_q),
        .out   (out_q),
        .blink (blink_q),
        .phase (blink_phase),
        .oe    (pin_oe),
        .drv   (pin_out)
    );

    // Export the polarity-adjusted input for an interrupt block.
    always_comb begin
        pin_level_adj = din_adj;
    end

endmodule

// File: rtl/gpio_bank_chk.sv
// Checker for gpio_bank, attached with bind. Assumes SYNC_STAGES == 2.
module gpio_bank_chk #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_level_adj,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  out_q,
    input logic [NPINS-1:0]  blink_q,
    input logic [NPINS-1:0]  pol_q
);
    import gpio_bank_pkg::*;

    logic [1:0]       since_rst;
    logic [NPINS-1:0] blink_mask;
    logic             stray_wr;

    // Count cycles since reset, saturating, to guard the two-deep history.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // Pins whose driven value should come from the blink phase.
    always_comb begin
        blink_mask = blink_q & ~dir_q;
        stray_wr   = bus_we && (32'(bus_addr) >= OFS_DIN);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dir_q == '0 && out_q == '0 && blink_q == '0 && pol_q == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && 32'(bus_addr) == OFS_DIR) |=> (pin_oe == ~$past(bus_wdata)));

    // R5
    out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && 32'(bus_addr) == OFS_OUT) |=>
            (((pin_out ^ $past(bus_wdata)) & ~blink_q) == '0));

    // R6
    blink_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & blink_mask) == '0) || ((pin_out & blink_mask) == blink_mask));

    // R7
    din_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (pin_level_adj == ($past(pin_in, 2) ^ pol_q)));

    // R8
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stray_wr |=> ($stable(dir_q) && $stable(out_q) && $stable(blink_q) && $stable(pol_q)));

endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .pin_in        (pin_in),
    .pin_oe        (pin_oe),
    .pin_out       (pin_out),
    .pin_level_adj (pin_level_adj),
    .dir_q         (dir_q),
    .out_q         (out_q),
    .blink_q       (blink_q),
    .pol_q         (pol_q)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;

    localparam int NPINS  = 32;
    localparam int ADDR_W = 4;
    localparam int HALF   = 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_we;
    logic [NPINS-1:0]  bus_wdata;
    logic [NPINS-1:0]  bus_rdata;
    logic [NPINS-1:0]  pin_in;
    logic [NPINS-1:0]  pin_oe;
    logic [NPINS-1:0]  pin_out;
    logic [NPINS-1:0]  pin_level_adj;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gpio_bank #(.NPINS(NPINS), .ADDR_W(ADDR_W), .SYNC_STAGES(2), .BLINK_HALF(HALF)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_we        (bus_we),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .pin_in        (pin_in),
        .pin_oe        (pin_oe),
        .pin_out       (pin_out),
        .pin_level_adj (pin_level_adj)
    );

    task automatic check(input string tag, input logic [NPINS-1:0] act, input logic [NPINS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one write; returns at the following falling edge.
    task automatic bus_write(input int a, input logic [NPINS-1:0] d);
        bus_addr  = ADDR_W'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    // Combinational read, taken between edges.
    task automatic bus_read(input int a, output logic [NPINS-1:0] d);
        bus_addr = ADDR_W'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [NPINS-1:0] v;
        for (int a = 0; a < 4; a++) begin
            bus_read(a, v);
            check("R1 register clear after reset", v, '0);
        end
        check("R1 pin_oe after reset", pin_oe, '1);
        check("R1 pin_out after reset", pin_out, '0);
    endtask

    task automatic t_readback();
        logic [NPINS-1:0] v;
        bus_write(1, 32'hA5A5_0F0F);
        bus_write(3, 32'h1234_5678);
        bus_read(1, v); check("R2 output-level readback", v, 32'hA5A5_0F0F);
        bus_read(3, v); check("R2 polarity readback", v, 32'h1234_5678);
        bus_read(0, v); check("R3 direction untouched", v, '0);
        bus_read(2, v); check("R3 blink untouched", v, '0);
        bus_write(3, '0);
    endtask

    task automatic t_rmw();
        logic [NPINS-1:0] v;
        bus_read(1, v);
        bus_write(1, v | 32'h0000_0020);
        bus_read(1, v); check("R3 read-modify-write set bit 5", v, 32'hA5A5_0F2F);
        bus_write(1, v & ~32'h0000_0001);
        bus_read(1, v); check("R3 read-modify-write clear bit 0", v, 32'hA5A5_0F2E);
    endtask

    task automatic t_oe_out();
        bus_write(0, 32'hFFFF_0000);
        check("R4 pin_oe from direction", pin_oe, 32'h0000_FFFF);
        check("R5 pin_out follows output level", pin_out, 32'hA5A5_0F2E);
        bus_write(1, 32'h0000_00C3);
        check("R5 pin_out after new level", pin_out, 32'h0000_00C3);
        bus_write(0, '0);
        check("R4 all outputs again", pin_oe, '1);
    endtask

    task automatic t_blink();
        logic prev;
        int   since;
        int   changes;
        bus_write(1, 32'h0000_0008);          // output bit 3 high, bit 9 low
        bus_write(2, 32'h0000_0208);          // blink pins 3 and 9
        prev    = pin_out[3];
        since   = 0;
        changes = 0;
        for (int c = 0; c < 6 * HALF; c++) begin
            @(negedge clk);
            since++;
            check("R6 blinking pins in lockstep", {31'b0, pin_out[9]}, {31'b0, pin_out[3]});
            if (pin_out[3] != prev) begin
                changes++;
                if (changes > 1)
                    check("R6 blink half period", NPINS'(since), NPINS'(HALF));
                since = 0;
                prev  = pin_out[3];
            end
        end
        check("R6 number of toggles seen", NPINS'(changes >= 5), NPINS'(1));
        bus_write(0, 32'h0000_0200);          // pin 9 becomes an input
        check("R9 blinking input pin not driven", {31'b0, pin_oe[9]}, '0);
        check("R9 other pin still driven", {31'b0, pin_oe[3]}, NPINS'(1));
        bus_write(2, '0);
        check("R5 blink off returns to output bit", pin_out & 32'h0000_0008, 32'h0000_0008);
        bus_write(0, '0);
    endtask

    task automatic t_din();
        logic [NPINS-1:0] v;
        bus_write(3, 32'h0000_00F0);
        bus_read(4, v); check("R7 data-in with polarity only", v, 32'h0000_00F0);
        pin_in = 32'h0000_0F0F;
        @(negedge clk);
        bus_read(4, v); check("R7 no change after one edge", v, 32'h0000_00F0);
        @(negedge clk);
        bus_read(4, v); check("R7 change after two edges", v, 32'h0000_0FFF);
        check("R7 exported level matches", pin_level_adj, 32'h0000_0FFF);
        bus_write(3, '0);
        bus_read(4, v); check("R7 polarity cleared", v, 32'h0000_0F0F);
    endtask

    task automatic t_stray();
        logic [NPINS-1:0] v;
        bus_write(0, 32'h0000_FF00);
        bus_write(1, 32'h1111_2222);
        bus_write(4, 32'hDEAD_BEEF);
        bus_write(7, 32'hDEAD_BEEF);
        bus_write(15, 32'hDEAD_BEEF);
        bus_read(0, v); check("R8 direction kept", v, 32'h0000_FF00);
        bus_read(1, v); check("R8 output level kept", v, 32'h1111_2222);
        bus_read(2, v); check("R8 blink kept", v, '0);
        bus_read(3, v); check("R8 polarity kept", v, '0);
        bus_read(7, v);  check("R8 unmapped read zero", v, '0);
        bus_read(15, v); check("R8 top unmapped read zero", v, '0);
    endtask

    initial begin
        rst_n     = 1'b0;
        bus_addr  = '0;
        bus_we    = 1'b0;
        bus_wdata = '0;
        pin_in    = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_rmw();
        t_oe_out();
        t_blink();
        t_din();
        t_stray();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule